// File: doc/BRIEF.md
# Serial Peripheral Port (Master/Slave)

This block is a byte-wide synchronous serial port that can run either as the clock-driving master or as a clocked slave. Software configures it through three registers and a narrow bus. In master mode, writing a byte to the data register starts an internal clock divider. The port then produces sixteen SCK edges, shifts the byte out on MOSI and captures MISO at the same time. When the last edge has passed it stops and raises an end-of-transfer flag. In slave mode, SCK, MOSI and the active-low select come in from outside. The port answers on MISO only while its select is held low. While the select is high the port is inert and leaves the data line free for other use.

The register map is as follows. Address 0 is control: bit 7 is the local interrupt enable, bit 6 the port enable, bit 5 LSB-first order, bit 4 master mode, bit 3 clock polarity (idle level), bit 2 clock phase, and bits 1:0 the rate code. Address 1 is status: bit 7 is the end-of-transfer flag and bit 6 the write-collision flag. Address 2 is data: a write loads the transmit byte and a read returns the last received byte. The interrupt request also depends on a port-level enable input. A wider controller drives that input, so two enables must agree before any request leaves the block.

Top module: `spi_port`

## Requirements
- R1: After reset, control, status and received data read as zero, irq is low, sck_o is low and sck_oe, mosi_oe and miso_oe are all low.
- R2: With control bits 6 and 4 set, a data-register write starts a transfer of exactly 16 SCK edges. sck_oe and mosi_oe are high. The written byte leaves on mosi_o, and the bits sampled from miso_i are returned by a later data-register read.
- R3: In master mode the SCK half period lasts 2, 8, 32 or 64 system clocks for rate codes 0, 1, 2 and 3, which are division ratios of 4, 16, 64 and 128.
- R4: SCK idles at the level of control bit 3, and the first edge leaves that level. With control bit 2 clear, data is sampled on odd-numbered edges (first, third, and so on) and changes on even-numbered ones. With it set, data changes on odd-numbered edges and is sampled on even-numbered ones.
- R5: Control bit 5 clear sends and receives the most significant bit first; set, the least significant bit first.
- R6: After the sixteenth edge the master stops, SCK rests at its idle level and status bit 7 is set.
- R7: Status bit 7 clears only when a status read that sees a flag set is followed by a data-register read or write. A data access with no such status read first leaves the flag set.
- R8: A data-register write during a transfer sets status bit 6 and is otherwise ignored: the byte on the wire is unchanged. The bit is cleared by the same sequence as R7.
- R9: irq is high exactly when status bit 7, control bit 7 and port_irq_en are all 1.
- R10: In slave mode (bit 6 set, bit 4 clear) with ss_n_i low, the port shifts on edges of sck_i using the mode of R4 and the order of R5. It drives miso_o with miso_oe high, captures mosi_i, and sets status bit 7 after sixteen edges.
- R11: In slave mode with ss_n_i high, sck_i edges have no effect. miso_oe and mosi_oe stay low, status stays clear, and the data register keeps its previous received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| port_irq_en | input | 1 | Port-level interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Master-out line sampled in slave mode |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Master-in line sampled in master mode |
| miso_o | output | 1 | Slave-out data |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench targets the last edge of the phase-1 modes, where a single edge both samples and shifts. A design that shifts before sampling there corrupts the final received bit. It times every SCK half period against the rate code, so a divider off by one cycle shows up on all four ratios. It writes to the data register mid-transfer to confirm that the collision flag rises while the byte on the wire stays intact. It also reads the data register before the status register to prove that the flag is not cleared by half of the sequence. Finally it toggles SCK with the slave deselected; a port that ignored the select would raise the flag or overwrite the received byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef enum logic [1:0] {
      RATE_DIV4   = 2'd0,
      RATE_DIV16  = 2'd1,
      RATE_DIV64  = 2'd2,
      RATE_DIV128 = 2'd3
   } rate_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   typedef struct packed {
      logic  irq_en;
      logic  port_on;
      logic  lsb_first;
      logic  is_master;
      logic  cpol;
      logic  cpha;
      rate_e rate;
   } ctrl_t;

   // system clocks per SCK half period
   function automatic int unsigned half_period(rate_e r);
      case (r)
         RATE_DIV4:   return 2;
         RATE_DIV16:  return 8;
         RATE_DIV64:  return 32;
         default:     return 64;
      endcase
   endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_port_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv
   import spi_port_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  rate_e rate,
   output logic  tick
);
   generate
      if ((1 << CNT_W) < 64) begin : g_bad_cnt
         $error("spi_port_clkdiv counter too narrow for the slowest rate");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   always_comb limit = CNT_W'(half_period(rate) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!run || cnt == limit) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == limit);

   // R3: even the fastest ratio leaves a quiet cycle between edges
   assert_sck_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          HAS_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lsb_first,
   input  logic              cpha,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              clear,
   input  logic              edge_stb,
   input  logic              in_bit,
   output logic              out_bit,
   output logic              mid,
   output logic              done,
   output logic [DATA_W-1:0] rx_data
);
   localparam int unsigned EDGES = 2 * DATA_W;
   localparam int unsigned CW    = $clog2(EDGES);

   logic [CW-1:0]     ecnt;
   logic [DATA_W-1:0] sr;
   logic [DATA_W-1:0] sr_shifted;
   logic              held;
   logic              last;
   logic              sample_now;
   logic              shift_now;
   logic              new_bit;

   assign last       = (ecnt == CW'(EDGES - 1));
   assign sample_now = edge_stb && (ecnt[0] == cpha);
   assign shift_now  = edge_stb && (((ecnt[0] != cpha) && (ecnt != '0)) || (cpha && last));
   assign new_bit    = sample_now ? in_bit : held;
   assign done       = edge_stb && last;
   assign mid        = (ecnt != '0);

   generate
      if (HAS_LSB) begin : g_both_orders
         always_comb begin
            out_bit    = lsb_first ? sr[0] : sr[DATA_W-1];
            sr_shifted = lsb_first ? {new_bit, sr[DATA_W-1:1]}
                                   : {sr[DATA_W-2:0], new_bit};
         end
      end else begin : g_msb_only
         logic unused_order;
         assign unused_order = lsb_first;
         always_comb begin
            out_bit    = sr[DATA_W-1];
            sr_shifted = {sr[DATA_W-2:0], new_bit};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt    <= '0;
         sr      <= '0;
         held    <= 1'b0;
         rx_data <= '0;
      end else if (load) begin
         sr   <= load_data;
         ecnt <= '0;
      end else if (clear) begin
         ecnt <= '0;
      end else if (edge_stb) begin
         ecnt <= last ? '0 : ecnt + 1'b1;
         if (sample_now) held <= in_bit;
         if (shift_now)  sr   <= sr_shifted;
         if (done)       rx_data <= sr_shifted;
      end
   end

   // R10: a finished byte needs sixteen more edges before the next end
   assert_single_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          HAS_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              port_irq_en,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_n_i
);
   localparam int unsigned DIV_W  = 6;
   localparam int unsigned CTRL_W = $bits(ctrl_t);

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("spi_port data width must hold the control register");
      end
   endgenerate

   ctrl_t ctrl_q;
   logic  flag_q, wcol_q, arm_q;
   logic  m_busy, sck_phase, sck_d;
   logic  sck_s, mosi_s, ss_n_s;
   logic  m_mode, s_mode, s_act, s_edge;
   logic  wr_ctrl, wr_data, rd_stat, acc_data;
   logic  xfer_busy, load, start, collide;
   logic  div_tick, edge_stb, xfer_done, shf_mid, shf_out, shf_clear, in_bit;
   logic [DATA_W-1:0] rx_data;

   // ---- pin synchronisers for the slave side
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));
   spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_n_s));

   // ---- decode
   assign m_mode   = ctrl_q.port_on & ctrl_q.is_master;
   assign s_mode   = ctrl_q.port_on & ~ctrl_q.is_master;
   assign s_act    = s_mode & ~ss_n_s;
   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
   assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
   assign acc_data = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);

   assign xfer_busy = m_busy | (s_act & shf_mid);
   assign load      = wr_data & ~xfer_busy;
   assign start     = load & m_mode;
   assign collide   = wr_data & xfer_busy;

   assign s_edge    = s_act & (sck_s ^ sck_d);
   assign edge_stb  = m_busy ? div_tick : s_edge;
   assign shf_clear = ~m_busy & ~s_act;
   assign in_bit    = m_busy ? miso_i : mosi_s;

   // ---- control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
   end

   // ---- master sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         m_busy <= 1'b0;
      else if (!m_mode)   m_busy <= 1'b0;
      else if (start)     m_busy <= 1'b1;
      else if (xfer_done) m_busy <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sck_phase <= 1'b0;
      else if (!m_busy)  sck_phase <= 1'b0;
      else if (div_tick) sck_phase <= ~sck_phase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   spi_port_clkdiv #(.CNT_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(ctrl_q.rate), .tick(div_tick));

   spi_port_shifter #(.DATA_W(DATA_W), .HAS_LSB(HAS_LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .lsb_first(ctrl_q.lsb_first), .cpha(ctrl_q.cpha),
      .load(load), .load_data(reg_wdata), .clear(shf_clear),
      .edge_stb(edge_stb), .in_bit(in_bit),
      .out_bit(shf_out), .mid(shf_mid), .done(xfer_done), .rx_data(rx_data));

   // ---- status flags and the two-step clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         wcol_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (xfer_done)              flag_q <= 1'b1;
         else if (arm_q && acc_data) flag_q <= 1'b0;
         if (collide)                wcol_q <= 1'b1;
         else if (arm_q && acc_data) wcol_q <= 1'b0;
         if (acc_data)                         arm_q <= 1'b0;
         else if (rd_stat && (flag_q | wcol_q)) arm_q <= 1'b1;
      end
   end

   // ---- read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_STAT: begin
            reg_rdata[7] = flag_q;
            reg_rdata[6] = wcol_q;
         end
         ADDR_DATA: reg_rdata = rx_data;
         default:   reg_rdata = '0;
      endcase
   end

   // ---- pins
   assign irq     = flag_q & ctrl_q.irq_en & port_irq_en;
   assign sck_o   = ctrl_q.cpol ^ sck_phase;
   assign sck_oe  = m_mode;
   assign mosi_o  = shf_out;
   assign mosi_oe = m_mode;
   assign miso_o  = shf_out;
   assign miso_oe = s_act;

   // R4: the master clock only moves on a divider tick
   assert_sck_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_busy && $past(m_busy) && !$past(div_tick)) |-> $stable(sck_phase));
   // R6: a completed master byte leaves SCK at its idle phase
   assert_idle_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(m_busy) && $past(xfer_done)) |-> !sck_phase);
   // R6: the flag rises only after the final edge
   assert_flag_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(xfer_done));
   // R8: collision flag has a mid-transfer data write behind it
   assert_wcol_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol_q) |-> $past(reg_wr && (reg_addr == ADDR_DATA) && xfer_busy));
endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
   import spi_port_pkg::*;

   localparam int DW = 8;
   localparam int HB = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          port_irq_en = 1'b0;
   logic          irq;
   logic          sck_i = 1'b0, sck_o, sck_oe;
   logic          mosi_i = 1'b0, mosi_o, mosi_oe;
   logic          miso_i = 1'b0, miso_o, miso_oe;
   logic          ss_n_i = 1'b1;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] last_rx = 8'h00;

   always #5 clk = ~clk;

   spi_port #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .port_irq_en(port_irq_en), .irq(irq),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .ss_n_i(ss_n_i));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic tx_bit(input logic [7:0] b, input int k, input bit lsb);
      return lsb ? b[k] : b[7-k];
   endfunction

   function automatic int half_cycles(input int r);
      case (r)
         0: return 2;
         1: return 8;
         2: return 32;
         default: return 64;
      endcase
   endfunction

   function automatic logic [7:0] ctrl_word(input bit ie, input bit on, input bit lsb,
                                            input bit mst, input bit cpol, input bit cpha,
                                            input int rate);
      return {ie, on, lsb, mst, cpol, cpha, rate[1:0]};
   endfunction

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic master_xfer(input bit ie, input bit pie, input bit lsb, input bit cpol,
                              input bit cpha, input int rate, input logic [7:0] tx,
                              input logic [7:0] slv, input bit collide);
      logic [7:0] got;
      logic [7:0] rd;
      logic       prev_sck;
      logic       prev_mosi;
      int         e;
      int         since;
      int         bad_period;
      int         h;
      got = '0; e = 0; since = 0; bad_period = 0; h = half_cycles(rate);
      port_irq_en = pie;
      reg_write(ADDR_CTRL, ctrl_word(ie, 1'b1, lsb, 1'b1, cpol, cpha, rate));
      check(sck_o == cpol && sck_oe && mosi_oe, "R4 idle level / R2 drive enables",
            {sck_o, sck_oe, mosi_oe}, {cpol, 2'b11});
      miso_i = cpha ? 1'b0 : tx_bit(slv, 0, lsb);
      prev_sck = sck_o;
      reg_write(ADDR_DATA, tx);
      if (collide) begin
         reg_write(ADDR_DATA, ~tx);
         since = 2;
      end
      prev_mosi = mosi_o;
      while (e < 16) begin
         @(negedge clk);
         since++;
         if (sck_o !== prev_sck) begin
            if (since != h) bad_period++;
            since = 0;
            if (e == 0) check(sck_o == !cpol, "R4 first edge leaves idle", sck_o, !cpol);
            if ((e % 2) == int'(cpha)) begin
               if (lsb) got[e/2] = prev_mosi;
               else     got[7 - e/2] = prev_mosi;
            end
            if (!cpha && (e % 2) == 1 && e < 15) miso_i = tx_bit(slv, (e + 1) / 2, lsb);
            if (cpha && (e % 2) == 0)            miso_i = tx_bit(slv, e / 2, lsb);
            prev_sck = sck_o;
            e++;
         end
         prev_mosi = mosi_o;
      end
      check(bad_period == 0, "R3 half period", bad_period, 0);
      check(got == tx, lsb ? "R5 lsb-first mosi byte" : "R2 msb-first mosi byte", got, tx);
      repeat (2) @(negedge clk);
      check(sck_o == cpol, "R6 sck back at idle", sck_o, cpol);
      check(irq == (ie & pie), "R9 irq gating", irq, ie & pie);
      reg_read(ADDR_STAT, rd);
      check(rd == {1'b1, collide, 6'b0}, collide ? "R8 collision flag" : "R6 end flag",
            rd, {1'b1, collide, 6'b0});
      reg_read(ADDR_DATA, rd);
      check(rd == slv, "R2 received miso byte", rd, slv);
      last_rx = slv;
      check(irq == 1'b0, "R9 irq drops with flag", irq, 0);
      reg_read(ADDR_STAT, rd);
      check(rd == 8'h00, "R7 status cleared by sequence", rd, 0);
   endtask

   task automatic slave_xfer(input bit ie, input bit pie, input bit lsb, input bit cpol,
                             input bit cpha, input logic [7:0] tx, input logic [7:0] mst);
      logic [7:0] got;
      logic [7:0] rd;
      got = '0;
      port_irq_en = pie;
      sck_i = cpol;
      ss_n_i = 1'b1;
      reg_write(ADDR_CTRL, ctrl_word(ie, 1'b1, lsb, 1'b0, cpol, cpha, 0));
      reg_write(ADDR_DATA, tx);
      repeat (4) @(negedge clk);
      check(!sck_oe && !mosi_oe && !miso_oe, "R11 released while deselected",
            {sck_oe, mosi_oe, miso_oe}, 0);
      ss_n_i = 1'b0;
      repeat (HB) @(negedge clk);
      check(miso_oe == 1'b1, "R10 miso driven when selected", miso_oe, 1);
      for (int k = 0; k < 8; k++) begin
         if (!cpha) begin
            mosi_i = tx_bit(mst, k, lsb);
            repeat (HB) @(negedge clk);
            sck_i = ~sck_i;
            if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
            repeat (HB) @(negedge clk);
            sck_i = ~sck_i;
         end else begin
            sck_i = ~sck_i;
            mosi_i = tx_bit(mst, k, lsb);
            repeat (HB) @(negedge clk);
            if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
            sck_i = ~sck_i;
            repeat (HB) @(negedge clk);
         end
      end
      repeat (HB) @(negedge clk);
      check(got == tx, "R10 slave miso byte", got, tx);
      check(irq == (ie & pie), "R9 irq gating slave", irq, ie & pie);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      reg_read(ADDR_DATA, rd);
      check(rd == mst, "R10 slave received mosi byte", rd, mst);
      last_rx = mst;
      reg_read(ADDR_STAT, rd);
      check(rd == 8'h80, "R7 data access alone keeps flag", rd, 8'h80);
      reg_read(ADDR_DATA, rd);
      reg_read(ADDR_STAT, rd);
      check(rd == 8'h00, "R7 flag cleared after status then data", rd, 0);
   endtask

   task automatic deselected_noise(input logic [7:0] pattern);
      logic [7:0] rd;
      int         oe_seen;
      oe_seen = 0;
      ss_n_i = 1'b1;
      sck_i = 1'b0;
      reg_write(ADDR_CTRL, ctrl_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0));
      for (int k = 0; k < 16; k++) begin
         mosi_i = pattern[k % 8];
         repeat (HB) @(negedge clk);
         sck_i = ~sck_i;
         if (miso_oe || mosi_oe) oe_seen++;
      end
      repeat (HB) @(negedge clk);
      check(oe_seen == 0, "R11 no drive while deselected", oe_seen, 0);
      reg_read(ADDR_STAT, rd);
      check(rd == 8'h00, "R11 no flag while deselected", rd, 0);
      reg_read(ADDR_DATA, rd);
      check(rd == last_rx, "R11 data unchanged while deselected", rd, last_rx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'h5a17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(irq == 1'b0 && sck_o == 1'b0, "R1 irq and sck after reset", {irq, sck_o}, 0);
      check(!sck_oe && !mosi_oe && !miso_oe, "R1 enables after reset",
            {sck_oe, mosi_oe, miso_oe}, 0);
      reg_read(ADDR_CTRL, rd); check(rd == 8'h00, "R1 control after reset", rd, 0);
      reg_read(ADDR_STAT, rd); check(rd == 8'h00, "R1 status after reset", rd, 0);
      reg_read(ADDR_DATA, rd); check(rd == 8'h00, "R1 data after reset", rd, 0);

      // directed: every rate, every phase mode
      for (int r = 0; r < 4; r++)
         master_xfer(1'b1, 1'b1, 1'b0, r[1], r[0], r, 8'hA5 ^ 8'(r), 8'h3C + 8'(r), 1'b0);
      // directed: the last edge in phase-1 mode, lsb order
      master_xfer(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 8'h81, 8'h7E, 1'b0);
      // directed: collision mid transfer
      master_xfer(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1, 8'hC3, 8'h5A, 1'b1);

      // directed: deselected slave ignores the clock
      deselected_noise(8'hF0);

      // random master traffic
      for (int n = 0; n < 16; n++) begin
         int          r;
         logic [31:0] v;
         v = $urandom;
         r = int'(v[1:0]);
         master_xfer(v[2], v[3], v[4], v[5], v[6], r, v[15:8], v[23:16],
                     (r != 0) && (v[25:24] == 2'b00));
      end

      // random slave traffic
      for (int n = 0; n < 10; n++) begin
         logic [31:0] v;
         v = $urandom;
         slave_xfer(v[2], v[3], v[4], v[5], v[6], v[15:8], v[23:16]);
      end

      deselected_noise(8'h3C);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule